// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between an internal request port and an external 128K x 8 static RAM with no clock. Each request is a single byte read or write. The block holds the request, then drives the RAM's address, two chip selects of opposite polarity, output enable and write enable through a fixed sequence. It keeps every phase open for a whole number of clock cycles, and parameters set that number from the clock period. The block also controls the tristate driver on the shared 8-bit data bus and registers the byte returned by a read.

A read keeps the chip selected with output enable low for a programmed number of cycles. The byte on the bus is sampled on the last edge of that window and returned with a one-cycle valid pulse. A write keeps output enable high and pulls write enable low. After a turnaround delay it drives the data. It then raises write enable while the chip is still selected, and holds the data for one more cycle after that edge. Every access ends with a recovery gap in which the chip is deselected. This gap lets the RAM release the bus before another access can start.

Cycle counts are set by `READ_CYC`, `WE_LOW_CYC`, `SETUP_CYC` and `TURN_CYC`. Each is the ceiling of the required time divided by the clock period, and a value below 1 is treated as 1. The write-enable low window `WLOW` is the larger of `WE_LOW_CYC` and `TURN_CYC + SETUP_CYC`.

Top module: `sram_port_ctrl`

## Requirements
- R1: During and after reset, and whenever idle, the RAM is deselected (`ram_cs_n`=1, `ram_cs`=0). Both strobes are high, the controller does not drive `ram_dq`, and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the access ends: `READ_CYC + TURN_CYC` cycles for a read, and `WLOW + 1 + TURN_CYC` cycles for a write. `req_valid` has no effect while `req_ready` is 0.
- R3: For the `READ_CYC` cycles after a read is taken, the chip is selected with `ram_oe_n`=0 and `ram_we_n`=1.
- R4: A read samples `ram_dq` on the edge that ends the read window. `rsp_valid` is 1 for exactly the following cycle, with that byte on `rsp_data`.
- R5: During a write, `ram_oe_n` stays 1 throughout. `ram_we_n` is 0 for `WLOW` cycles, and the chip stays selected for one more cycle after `ram_we_n` returns to 1.
- R6: The controller drives the write byte latched at acceptance onto `ram_dq` from `TURN_CYC` cycles after `ram_we_n` falls, through the cycle after `ram_we_n` rises. At all other times it releases the bus. Data is therefore on the bus for at least `SETUP_CYC` cycles before the rising edge and still on the bus at that edge.
- R7: After each access the chip is deselected with both strobes high for `TURN_CYC` cycles before the next request can be taken.
- R8: `ram_addr` equals the accepted address and does not change while the chip is selected.
- R9: `ram_we_n` and `ram_oe_n` are never both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | 8 | Byte returned by a read |
| ram_addr | output | 17 | RAM address pins |
| ram_dq | inout | 8 | RAM bidirectional data bus |
| ram_cs_n | output | 1 | Active-low chip select |
| ram_cs | output | 1 | Active-high chip select |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write enable |

## Verification
The assertions assume the RAM drives `ram_dq` only while it is selected, `ram_oe_n` is 0 and `ram_we_n` is 1. They also assume every count parameter is at least 1 and that reset is released between clock edges. The stimulus respects these assumptions. The bench's RAM model drives the bus only in the read condition and stores a byte on the rising edge of `ram_we_n` while selected. Requests change only at falling clock edges, and the bench sometimes leaves `req_valid` asserted during a busy access and changes `req_wdata` right after acceptance, to show that only the latched values reach the pins.

// File: rtl/sram_port_pkg.sv
`timescale 1ns/1ps
package sram_port_pkg;

    // Access phases of the sequencer
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_READ    = 3'd1,
        PH_WR_LOW  = 3'd2,
        PH_WR_HOLD = 3'd3,
        PH_GAP     = 3'd4
    } phase_e;

    function automatic int clamp1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic [CW-1:0] left,
    output logic          done
);

    logic [CW-1:0] cnt_d, cnt_q;

    // Loading N makes done rise in the Nth cycle after the load edge
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = len - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign left = cnt_q;
    assign done = (cnt_q == '0);

    // every phase lasts at least one cycle (R7 gap included)
    p_len_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0));

endmodule

// File: rtl/sram_dq_pad.sv
`timescale 1ns/1ps
module sram_dq_pad #(
    parameter int DW = 8
) (
    input  logic          drive_en,
    input  logic [DW-1:0] out_val,
    output logic [DW-1:0] in_val,
    inout  wire  [DW-1:0] pad
);

    assign pad    = drive_en ? out_val : {DW{1'bz}};
    assign in_val = pad;

endmodule

// File: rtl/sram_port_ctrl.sv
`timescale 1ns/1ps
module sram_port_ctrl
    import sram_port_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int READ_CYC   = 3,
    parameter int WE_LOW_CYC = 2,
    parameter int SETUP_CYC  = 2,
    parameter int TURN_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] ram_addr,
    inout  wire  [DATA_W-1:0] ram_dq,
    output logic              ram_cs_n,
    output logic              ram_cs,
    output logic              ram_oe_n,
    output logic              ram_we_n
);

    localparam int RD_L   = clamp1(READ_CYC);
    localparam int WE_L   = clamp1(WE_LOW_CYC);
    localparam int SU_L   = clamp1(SETUP_CYC);
    localparam int TN_L   = clamp1(TURN_CYC);
    localparam int WLOW   = max2(WE_L, TN_L + SU_L);
    localparam int MAXC   = max2(RD_L, WLOW);
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam int DRV_AT = WLOW - TN_L;

    typedef struct packed {
        phase_e             phase;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic               rvalid;
        logic               sel;
        logic               oe_n;
        logic               we_n;
        logic               drv;
    } ctl_s;

    localparam ctl_s CTL_RESET = '{
        phase:  PH_IDLE,
        addr:   '0,
        wdata:  '0,
        rdata:  '0,
        rvalid: 1'b0,
        sel:    1'b0,
        oe_n:   1'b1,
        we_n:   1'b1,
        drv:    1'b0
    };

    ctl_s              r_d, r_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_len;
    logic [CNT_W-1:0]  tmr_left;
    logic              tmr_done;
    logic [DATA_W-1:0] dq_in;

    sram_phase_timer #(.CW(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .left  (tmr_left),
        .done  (tmr_done)
    );

    sram_dq_pad #(.DW(DATA_W)) u_pad (
        .drive_en (r_q.drv),
        .out_val  (r_q.wdata),
        .in_val   (dq_in),
        .pad      (ram_dq)
    );

    always_comb begin
        r_d      = r_q;
        r_d.rvalid = 1'b0;
        tmr_load = 1'b0;
        tmr_len  = '0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.sel   = 1'b1;
                    tmr_load  = 1'b1;
                    if (req_write) begin
                        r_d.phase = PH_WR_LOW;
                        r_d.we_n  = 1'b0;
                        r_d.oe_n  = 1'b1;
                        tmr_len   = CNT_W'(WLOW);
                    end else begin
                        r_d.phase = PH_READ;
                        r_d.oe_n  = 1'b0;
                        tmr_len   = CNT_W'(RD_L);
                    end
                end
            end
            PH_READ: begin
                if (tmr_done) begin
                    r_d.rdata  = dq_in;
                    r_d.rvalid = 1'b1;
                    r_d.sel    = 1'b0;
                    r_d.oe_n   = 1'b1;
                    r_d.phase  = PH_GAP;
                    tmr_load   = 1'b1;
                    tmr_len    = CNT_W'(TN_L);
                end
            end
            PH_WR_LOW: begin
                // turn the driver on once the turnaround count has elapsed
                if (tmr_left <= CNT_W'(DRV_AT)) begin
                    r_d.drv = 1'b1;
                end
                if (tmr_done) begin
                    r_d.we_n  = 1'b1;
                    r_d.phase = PH_WR_HOLD;
                end
            end
            PH_WR_HOLD: begin
                r_d.drv   = 1'b0;
                r_d.sel   = 1'b0;
                r_d.phase = PH_GAP;
                tmr_load  = 1'b1;
                tmr_len   = CNT_W'(TN_L);
            end
            PH_GAP: begin
                if (tmr_done) begin
                    r_d.phase = PH_IDLE;
                end
            end
            default: begin
                r_d = CTL_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CTL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.phase == PH_IDLE);
    assign rsp_valid = r_q.rvalid;
    assign rsp_data  = r_q.rdata;
    assign ram_addr  = r_q.addr;
    assign ram_cs_n  = ~r_q.sel;
    assign ram_cs    = r_q.sel;
    assign ram_oe_n  = r_q.oe_n;
    assign ram_we_n  = r_q.we_n;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_cs_n && !ram_cs && ram_we_n && ram_oe_n && !r_q.drv));

    p_take_then_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rvalid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_drive_oe_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.drv |-> (ram_oe_n && ram_cs));

    p_data_at_we_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> r_q.drv);

    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs && $past(ram_cs)) |-> $stable(ram_addr));

    p_no_strobe_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ram_we_n && !ram_oe_n));

endmodule

// File: tb/sram_port_ctrl_test.sv
`timescale 1ns/1ps
module sram_port_ctrl_test;

    localparam int RD   = 3;
    localparam int WEC  = 2;
    localparam int SU   = 2;
    localparam int TN   = 2;
    localparam int WLOW = (WEC > TN + SU) ? WEC : TN + SU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic [16:0] ram_addr;
    wire  [7:0]  ram_dq;
    logic        ram_cs_n, ram_cs, ram_oe_n, ram_we_n;

    always #2.5 clk = ~clk;

    sram_port_ctrl #(
        .ADDR_W(17), .DATA_W(8), .READ_CYC(RD), .WE_LOW_CYC(WEC),
        .SETUP_CYC(SU), .TURN_CYC(TN)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .ram_addr(ram_addr), .ram_dq(ram_dq),
        .ram_cs_n(ram_cs_n), .ram_cs(ram_cs), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
    );

    // ---------------- RAM model ----------------
    logic [7:0] cells [int];
    int         ver = 0;

    function automatic logic [7:0] dflt(input logic [16:0] a);
        return a[7:0] ^ {1'b0, a[16:10]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] cell_val(input logic [16:0] a, input int v);
        if (v < 0) return 8'h00;
        if (cells.exists(int'(a))) return cells[int'(a)];
        return dflt(a);
    endfunction

    wire ram_rd = (ram_cs === 1'b1) && (ram_cs_n === 1'b0) &&
                  (ram_oe_n === 1'b0) && (ram_we_n === 1'b1);
    assign ram_dq = ram_rd ? cell_val(ram_addr, ver) : 8'hzz;

    always @(posedge ram_we_n) begin
        if (ram_cs === 1'b1 && ram_cs_n === 1'b0) begin
            cells[int'(ram_addr)] = ram_dq;
            ver = ver + 1;
        end
    end

    // ---------------- reference model ----------------
    logic [7:0]  ref_mem [int];
    int          mode = 0;      // 0 idle, 1 read, 2 write
    int          s = 0;
    logic [16:0] m_addr = '0;
    logic [7:0]  m_wdata = '0;
    logic [7:0]  m_rexp = '0;
    bit          accepted = 0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic e_sel, e_oe_n, e_we_n, e_drv, e_rv;
        string tag;
        e_sel = 0; e_oe_n = 1; e_we_n = 1; e_drv = 0; e_rv = 0; tag = "R1";
        if (mode == 1) begin
            if (s < RD) begin e_sel = 1; e_oe_n = 0; tag = "R3"; end
            else begin tag = "R7"; e_rv = (s == RD); end
        end else if (mode == 2) begin
            if (s < WLOW) begin e_sel = 1; e_we_n = 0; e_drv = (s >= TN); tag = "R5"; end
            else if (s == WLOW) begin e_sel = 1; e_drv = 1; tag = "R5"; end
            else tag = "R7";
        end
        chk("R2", "req_ready", req_ready, (mode == 0));
        chk(tag, "ram_cs_n", ram_cs_n, !e_sel);
        chk(tag, "ram_cs", ram_cs, e_sel);
        chk(tag, "ram_oe_n", ram_oe_n, e_oe_n);
        chk(tag, "ram_we_n", ram_we_n, e_we_n);
        chk("R9", "strobe clash", (!ram_oe_n && !ram_we_n), 1'b0);
        chk("R4", "rsp_valid", rsp_valid, e_rv);
        if (e_rv) chk("R4", "rsp_data", rsp_data, m_rexp);
        if (e_sel) chk("R8", "ram_addr", ram_addr, m_addr);
        if (e_drv) chk("R6", "ram_dq driven", ram_dq, m_wdata);
    endtask

    task automatic step();
        @(posedge clk);
        accepted = 0;
        if (mode == 0) begin
            if (req_valid) begin
                mode = req_write ? 2 : 1;
                s = 0;
                m_addr = req_addr;
                m_wdata = req_wdata;
                accepted = 1;
                if (req_write) ref_mem[int'(req_addr)] = req_wdata;
                else m_rexp = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : dflt(req_addr);
            end
        end else begin
            s++;
            if ((mode == 1 && s == RD + TN) || (mode == 2 && s == WLOW + 1 + TN)) mode = 0;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        do step(); while (!accepted);
        req_valid = 0;
        req_wdata = ~d;          // latched copy must be what reaches the bus (R6)
        req_addr  = ~a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #250000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog actual=hung expected=completed");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        compare_all();
        chk("R1", "reset ready", req_ready, 1'b1);
        rst_n = 1;
        idle(2);

        // R5 R6: writes at address extremes and data extremes
        issue(1, 17'h00000, 8'hA5);
        issue(1, 17'h1FFFF, 8'hFF);
        issue(1, 17'h12345, 8'h00);
        idle(3);
        // R3 R4: read them back, plus an unwritten location
        issue(0, 17'h00000, 8'h11);
        issue(0, 17'h1FFFF, 8'h22);
        issue(0, 17'h12345, 8'h33);
        issue(0, 17'h0ABCD, 8'h44);
        // write then read the same address back to back, then overwrite
        issue(1, 17'h12345, 8'h3C);
        issue(0, 17'h12345, 8'h00);
        issue(1, 17'h12345, 8'hC3);
        issue(0, 17'h12345, 8'h00);
        idle(1);
        // pattern sweep
        for (int i = 0; i < 24; i++) begin
            issue(1, 17'(i * 5347 + 7), 8'(i * 37 + 1));
        end
        for (int i = 23; i >= 0; i--) begin
            issue(0, 17'(i * 5347 + 7), 8'h00);
            if (i % 5 == 0) idle(2);
        end
        idle(8);
        chk("R1", "final idle ready", req_ready, 1'b1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule